// File: doc/BRIEF.md
# Multi-comparator event timer

This block is a memory-mapped event timer. A single free-running up-counter advances once per clock while a global run bit is set. Several comparator channels watch it, and each channel can raise its own interrupt line. A channel either fires once, when the counter equals its comparator, or fires repeatedly. In the repeating case the comparator advances by a stored period after every match. The interrupt can be a one-cycle pulse or a held level. A held level is latched in a status bit, and software clears that bit by writing 1.

Software reaches every register through one read/write port. All accesses are 64 bits wide and aligned to 8 bytes. Reads return data one clock after the request. A 32-bit mode on each channel restricts the comparison to the low half of the counter, and the reload then wraps at 32 bits. Accesses with nonzero low address bits [2:0] are ignored.

Top module: `evt_timer`

## Requirements
- R1: The capability word at address 0x000 reads as follows. Bits 7:0 hold the revision parameter and bits 12:8 hold the channel count minus one. Bit 13 is 1, reporting a 64-bit counter. Bits 14 and 15 are 0, so no legacy capability is reported. Bits 31:16 hold the vendor parameter and bits 63:32 hold the tick-period parameter.
- R2: The counter sits at address 0x0F0. It increments by one per clock while global configuration bit 0 (address 0x010) is 1 and holds otherwise. A write to it takes effect only while bit 0 is 0 and is ignored while the counter runs.
- R3: In one-shot mode (channel configuration bit 3 = 0) a channel matches only in a cycle where the running counter equals its comparator. The match sets its status bit and irq one clock later, and the channel does not fire again once the counter has passed the value.
- R4: Channel n has its configuration at 0x100+0x20·n and its comparator at +8. A comparator write in periodic mode (bit 3 = 1) with bit 6 = 1 loads both the comparator and the period. Bit 6 then reads 0. On each match in periodic mode the comparator increases by the period.
- R5: In level mode (bit 1 = 1) a match sets the channel's bit n in the status word at 0x020, and the bit stays set. Writing 0 to it has no effect and writing 1 clears it. irq[n] equals the status bit ANDed with channel bit 2 (interrupt enable).
- R6: In edge mode (bit 1 = 0) each match with bit 2 set gives a one-clock pulse on irq[n]. The status bit stays 0, and a configuration write with bit 1 = 0 clears it.
- R7: With bit 8 = 1 the match compares only the low 32 bits of the counter and comparator. The periodic reload result is truncated to 32 bits.
- R8: When a hardware match and a write-1 clear of the same status bit fall in the same clock, the bit ends set.
- R9: After reset the configuration, status, counter and comparators read 0 and all irq lines are low.
- R10: A channel configuration read returns route bits 13:9, bit 8, bit 6 and bits 3:1 as written. Bits 4 and 5 read 1 (periodic and 64-bit capable). Bits 63:32 hold the route-mask parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the clock after reg_rd |
| irq | output | NUM_CH | Per-channel interrupt outputs |

## Verification
A status bit can be set by a comparator match and cleared by a software write-1 in the same clock. The bench provokes this by starting the counter at zero and timing a status write so that it lands on exactly the clock edge where the match is registered. It counts clocks from the enabling write to find that edge. It then judges the outcome by reading the status word and sampling irq: both must show the bit still set. A second collision is also possible, between a periodic reload and a comparator write. The bench keeps those apart so that every interval it measures comes only from the reload.

// File: rtl/evt_timer_pkg.sv
// Package: shared register offsets and channel configuration layout for
// the event timer. Assumes 12-bit byte addresses and 8-byte registers.
package evt_timer_pkg;

    localparam logic [11:0] OFS_CAP  = 12'h000;
    localparam logic [11:0] OFS_GCFG = 12'h010;
    localparam logic [11:0] OFS_STS  = 12'h020;
    localparam logic [11:0] OFS_CNT  = 12'h0F0;
    localparam int          CH_BASE_IDX = 8;     // 0x100 >> 5
    localparam int          CH_STRIDE_LG = 5;    // 0x20 bytes per channel

    // channel configuration bit positions
    localparam int CB_LEVEL    = 1;
    localparam int CB_IE       = 2;
    localparam int CB_PER      = 3;
    localparam int CB_PER_CAP  = 4;
    localparam int CB_WIDE_CAP = 5;
    localparam int CB_VS       = 6;
    localparam int CB_M32      = 8;
    localparam int CB_ROUTE_LO = 9;
    localparam int ROUTE_W     = 5;

    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic               m32;
        logic               vs;
        logic               per;
        logic               ie;
        logic               lvl;
    } ch_cfg_t;

endpackage

// File: rtl/evt_main_counter.sv
// Module: the free-running main up-counter.
// Assumes: a load is honoured only while the counter is stopped.
module evt_main_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    // advance while running, accept software loads only when stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (load) begin
            cnt_q <= load_val;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/evt_channel.sv
// Module: one comparator channel with its configuration, comparator,
// period, level status and interrupt output.
// Assumes: cfg_we and cmp_we never assert together (distinct addresses);
// CNT_W is at least 33 and at most 64.
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter int          CNT_W      = 64,
    parameter logic [31:0] ROUTE_MASK = 32'h0000_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cfg_we,
    input  logic             cmp_we,
    input  logic             sts_clr,
    input  logic [63:0]      wdata,
    output logic [63:0]      cfg_rd,
    output logic [63:0]      cmp_rd,
    output logic             sts,
    output logic             lvl,
    output logic             vs,
    output logic             irq
);

    localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'({32{1'b1}});

    ch_cfg_t          cfg_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] per_q;
    logic             sts_q;
    logic             pulse_q;

    logic             eq;
    logic             match;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] wr_val;

    // comparison over the full width or, in 32-bit mode, the low half
    always_comb begin
        if (cfg_q.m32) begin
            eq = (cnt[31:0] == cmp_q[31:0]);
        end else begin
            eq = (cnt == cmp_q);
        end
        match = run && eq;
    end

    // next comparator after a periodic match, and masked software value
    always_comb begin
        reload = cmp_q + per_q;
        wr_val = wdata[CNT_W-1:0];
        if (cfg_q.m32) begin
            reload = reload & LOW_MASK;
            wr_val = wr_val & LOW_MASK;
        end
    end

    // configuration register; value-set bit self-clears on comparator write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.lvl   <= wdata[CB_LEVEL];
            cfg_q.ie    <= wdata[CB_IE];
            cfg_q.per   <= wdata[CB_PER];
            cfg_q.vs    <= wdata[CB_VS];
            cfg_q.m32   <= wdata[CB_M32];
            cfg_q.route <= wdata[CB_ROUTE_LO +: ROUTE_W];
        end else if (cmp_we) begin
            cfg_q.vs <= 1'b0;
        end
    end

    // comparator: software write wins over a periodic reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_we) begin
            cmp_q <= wr_val;
        end else if (match && cfg_q.per) begin
            cmp_q <= reload;
        end
    end

    // period register captured on a value-set comparator write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
        end else if (cmp_we && cfg_q.per && cfg_q.vs) begin
            per_q <= wr_val;
        end
    end

    // level status: hardware set beats a write-1 clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (cfg_we && !wdata[CB_LEVEL]) begin
            sts_q <= 1'b0;
        end else if (match && cfg_q.lvl) begin
            sts_q <= 1'b1;
        end else if (sts_clr) begin
            sts_q <= 1'b0;
        end
    end

    // one-cycle pulse for edge-mode matches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= match && cfg_q.ie && !cfg_q.lvl;
        end
    end

    // read-back words and interrupt output
    always_comb begin
        cfg_rd                           = '0;
        cfg_rd[63:32]                    = ROUTE_MASK;
        cfg_rd[CB_ROUTE_LO +: ROUTE_W]   = cfg_q.route;
        cfg_rd[CB_M32]                   = cfg_q.m32;
        cfg_rd[CB_VS]                    = cfg_q.vs;
        cfg_rd[CB_WIDE_CAP]              = 1'b1;
        cfg_rd[CB_PER_CAP]               = 1'b1;
        cfg_rd[CB_PER]                   = cfg_q.per;
        cfg_rd[CB_IE]                    = cfg_q.ie;
        cfg_rd[CB_LEVEL]                 = cfg_q.lvl;
        cmp_rd                           = 64'(cmp_q);
        irq = cfg_q.lvl ? (sts_q && cfg_q.ie) : pulse_q;
    end

    assign sts = sts_q;
    assign lvl = cfg_q.lvl;
    assign vs  = cfg_q.vs;

endmodule

// File: rtl/evt_timer.sv
// Module: top of the multi-comparator event timer. Decodes the register
// port, holds the global configuration, instantiates the main counter and
// NUM_CH channels, and registers read data.
// Assumes: 64-bit aligned accesses; misaligned accesses are ignored;
// NUM_CH is between 1 and 32.
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int          NUM_CH     = 3,
    parameter int          CNT_W      = 64,
    parameter logic [7:0]  REVISION   = 8'h01,
    parameter logic [15:0] VENDOR     = 16'h0001,
    parameter logic [31:0] TICK_FS    = 32'd10_000_000,
    parameter logic [31:0] ROUTE_MASK = 32'h0000_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [11:0]       reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam logic [4:0] CH_LAST = 5'(NUM_CH - 1);
    localparam logic [63:0] CAP_WORD = {TICK_FS, VENDOR, 1'b0, 1'b0, 1'b1,
                                        CH_LAST, REVISION};

    logic              run_q;
    logic              legacy_q;
    logic              aligned;
    logic              hit_cap;
    logic              hit_gcfg;
    logic              hit_sts;
    logic              hit_cnt;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt;
    logic [NUM_CH-1:0] ch_cfg_hit;
    logic [NUM_CH-1:0] ch_cmp_hit;
    logic [NUM_CH-1:0] ch_cfg_we;
    logic [NUM_CH-1:0] ch_cmp_we;
    logic [NUM_CH-1:0] ch_sts_clr;
    logic [NUM_CH-1:0] ch_sts;
    logic [NUM_CH-1:0] ch_lvl;
    logic [NUM_CH-1:0] ch_vs;
    logic [63:0]       ch_cfg_rd [NUM_CH];
    logic [63:0]       ch_cmp_rd [NUM_CH];
    logic [63:0]       rd_mux;

    // decode of the global registers
    always_comb begin
        aligned  = (reg_addr[2:0] == 3'b000);
        hit_cap  = aligned && (reg_addr[11:3] == OFS_CAP[11:3]);
        hit_gcfg = aligned && (reg_addr[11:3] == OFS_GCFG[11:3]);
        hit_sts  = aligned && (reg_addr[11:3] == OFS_STS[11:3]);
        hit_cnt  = aligned && (reg_addr[11:3] == OFS_CNT[11:3]);
        cnt_load = reg_wr && hit_cnt;
    end

    // global configuration: run and legacy-route bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            legacy_q <= 1'b0;
        end else if (reg_wr && hit_gcfg) begin
            run_q    <= reg_wdata[0];
            legacy_q <= reg_wdata[1];
        end
    end

    evt_main_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .load     (cnt_load),
        .load_val (reg_wdata[CNT_W-1:0]),
        .cnt      (cnt)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        // per-channel address decode and strobes
        always_comb begin
            ch_cfg_hit[n] = aligned
                && (reg_addr[11:CH_STRIDE_LG] == 7'(CH_BASE_IDX + n))
                && (reg_addr[4:3] == 2'd0);
            ch_cmp_hit[n] = aligned
                && (reg_addr[11:CH_STRIDE_LG] == 7'(CH_BASE_IDX + n))
                && (reg_addr[4:3] == 2'd1);
            ch_cfg_we[n]  = reg_wr && ch_cfg_hit[n];
            ch_cmp_we[n]  = reg_wr && ch_cmp_hit[n];
            ch_sts_clr[n] = reg_wr && hit_sts && reg_wdata[n];
        end

        evt_channel #(
            .CNT_W      (CNT_W),
            .ROUTE_MASK (ROUTE_MASK)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_q),
            .cnt     (cnt),
            .cfg_we  (ch_cfg_we[n]),
            .cmp_we  (ch_cmp_we[n]),
            .sts_clr (ch_sts_clr[n]),
            .wdata   (reg_wdata),
            .cfg_rd  (ch_cfg_rd[n]),
            .cmp_rd  (ch_cmp_rd[n]),
            .sts     (ch_sts[n]),
            .lvl     (ch_lvl[n]),
            .vs      (ch_vs[n]),
            .irq     (irq[n])
        );
    end

    // read data selection
    always_comb begin
        rd_mux = '0;
        if (hit_cap) begin
            rd_mux = CAP_WORD;
        end else if (hit_gcfg) begin
            rd_mux = {62'd0, legacy_q, run_q};
        end else if (hit_sts) begin
            rd_mux = 64'(ch_sts);
        end else if (hit_cnt) begin
            rd_mux = 64'(cnt);
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_cfg_hit[i]) rd_mux = ch_cfg_rd[i];
                if (ch_cmp_hit[i]) rd_mux = ch_cmp_rd[i];
            end
        end
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/evt_timer_chk.sv
// Module: assertion checker for the event timer, bound to the top.
// Assumes: connected to the top's counter, run bit and channel state.
module evt_timer_chk #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              cnt_load,
    input logic [CNT_W-1:0]  cnt,
    input logic [NUM_CH-1:0] sts,
    input logic [NUM_CH-1:0] lvl,
    input logic [NUM_CH-1:0] vs,
    input logic [NUM_CH-1:0] cmp_we
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt == $past(cnt) + 1'b1));                        // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_load) |=> $stable(cnt));                      // R2

    AST_STS_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ~$past(sts)) != '0) |-> $past(run));                // R5

    AST_EDGE_NO_STS: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ~lvl) == '0));                                      // R6

    AST_VS_SELF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we != '0) |=> ((vs & $past(cmp_we)) == '0));           // R4

endmodule

bind evt_timer evt_timer_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .cnt_load (cnt_load),
    .cnt      (cnt),
    .sts      (ch_sts),
    .lvl      (ch_lvl),
    .vs       (ch_vs),
    .cmp_we   (ch_cmp_we)
);

// File: tb/evt_timer_bench.sv
// Directed bench for the event timer: one task per scenario.
module evt_timer_bench;

    localparam int          NCH   = 3;
    localparam logic [7:0]  REV   = 8'h02;
    localparam logic [15:0] VEND  = 16'hA5C3;
    localparam logic [31:0] TICK  = 32'd10_000_000;
    localparam logic [31:0] RMASK = 32'h00F0_0F00;

    localparam logic [11:0] A_CAP  = 12'h000;
    localparam logic [11:0] A_GCFG = 12'h010;
    localparam logic [11:0] A_STS  = 12'h020;
    localparam logic [11:0] A_CNT  = 12'h0F0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [11:0]     reg_addr = '0;
    logic [63:0]     reg_wdata = '0;
    logic [63:0]     reg_rdata;
    logic [NCH-1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    evt_timer #(
        .NUM_CH (NCH), .CNT_W (64), .REVISION (REV),
        .VENDOR (VEND), .TICK_FS (TICK), .ROUTE_MASK (RMASK)
    ) u_evt_timer (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_rd (reg_rd),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .irq (irq)
    );

    function automatic logic [11:0] a_cfg(input int ch);
        return 12'(12'h100 + 32 * ch);
    endfunction

    function automatic logic [11:0] a_cmp(input int ch);
        return 12'(12'h108 + 32 * ch);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // counts clock edges until irq[ch] is high, starting after a write
    task automatic wait_irq(input int ch, input int limit, output int n);
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (!irq[ch] && n < limit);
    endtask

    // stop counter, zero it, and clear every channel
    task automatic quiesce(input logic [63:0] start);
        do_wr(A_GCFG, 64'h0);
        do_wr(A_CNT, start);
        for (int c = 0; c < NCH; c++) do_wr(a_cfg(c), 64'h0);
        do_wr(A_STS, 64'hFFFF_FFFF);
    endtask

    task automatic t_reset;
        logic [63:0] d;
        do_rd(A_GCFG, d); check(d == 0, "R9 gcfg", d, 0);
        do_rd(A_STS, d);  check(d == 0, "R9 status", d, 0);
        do_rd(A_CNT, d);  check(d == 0, "R9 counter", d, 0);
        do_rd(a_cmp(0), d); check(d == 0, "R9 cmp0", d, 0);
        check(irq == 0, "R9 irq", 64'(irq), 0);
    endtask

    task automatic t_cap;
        logic [63:0] d, e;
        e = {TICK, VEND, 3'b001, 5'(NCH - 1), REV};
        do_rd(A_CAP, d); check(d == e, "R1 capability", d, e);
    endtask

    task automatic t_counter;
        logic [63:0] d, d2;
        do_wr(A_CNT, 64'd100);
        do_rd(A_CNT, d); check(d == 100, "R2 load stopped", d, 100);
        do_wr(A_GCFG, 64'h1);
        do_wr(A_CNT, 64'd5);
        do_rd(A_CNT, d); check(d > 100, "R2 write ignored running", d, 101);
        do_wr(A_GCFG, 64'h3);
        do_rd(A_GCFG, d); check(d == 3, "R10 gcfg readback", d, 3);
        do_wr(A_GCFG, 64'h0);
        do_rd(A_CNT, d); do_rd(A_CNT, d2);
        check(d == d2, "R2 hold stopped", d2, d);
    endtask

    task automatic t_level_oneshot;
        logic [63:0] d; int n;
        quiesce(64'd0);
        do_wr(a_cfg(0), 64'h6);
        do_wr(a_cmp(0), 64'd20);
        do_wr(A_GCFG, 64'h1);
        wait_irq(0, 100, n);
        check(n == 21, "R3 match latency", 64'(n), 21);
        do_rd(A_STS, d); check(d == 1, "R5 status set", d, 1);
        do_wr(A_STS, 64'h0);
        do_rd(A_STS, d); check(d == 1, "R5 write0 no effect", d, 1);
        check(irq[0] == 1'b1, "R5 irq held", 64'(irq), 1);
        do_wr(A_STS, 64'h1);
        do_rd(A_STS, d); check(d == 0, "R5 write1 clears", d, 0);
        check(irq[0] == 1'b0, "R5 irq dropped", 64'(irq), 0);
        repeat (40) @(posedge clk);
        #1;
        do_rd(A_STS, d); check(d == 0, "R3 fires once", d, 0);
    endtask

    task automatic t_edge_periodic;
        logic [63:0] d, e; int n;
        quiesce(64'd0);
        do_wr(a_cfg(1), 64'h4C);
        do_wr(a_cmp(1), 64'd10);
        e = {RMASK, 32'h3C};
        do_rd(a_cfg(1), d); check(d == e, "R4 R10 cfg, value-set cleared", d, e);
        do_wr(A_GCFG, 64'h1);
        wait_irq(1, 100, n);
        check(n == 11, "R6 first pulse", 64'(n), 11);
        @(posedge clk); #1;
        check(irq[1] == 1'b0, "R6 pulse one cycle", 64'(irq), 0);
        wait_irq(1, 100, n);
        check(n == 9, "R4 period reload", 64'(n), 9);
        do_rd(A_STS, d); check(d == 0, "R6 status unused", d, 0);
        do_wr(a_cfg(1), 64'h0);
    endtask

    task automatic t_mode32;
        logic [63:0] d, e; int n;
        quiesce(64'h1_0000_0000);
        do_wr(a_cfg(2), 64'h104);
        do_wr(a_cmp(2), 64'd8);
        do_wr(A_GCFG, 64'h1);
        wait_irq(2, 100, n);
        check(n == 9, "R7 low-half compare", 64'(n), 9);
        quiesce(64'hFFFF_FFE0);
        do_wr(a_cfg(2), 64'hB4C);
        do_wr(a_cmp(2), 64'h20);
        do_wr(a_cmp(2), 64'hFFFF_FFF0);
        e = {RMASK, 32'hB3C};
        do_rd(a_cfg(2), d); check(d == e, "R10 route readback", d, e);
        do_wr(A_GCFG, 64'h1);
        wait_irq(2, 100, n);
        check(n == 17, "R7 first match", 64'(n), 17);
        wait_irq(2, 100, n);
        check(n == 32, "R7 wrapped reload interval", 64'(n), 32);
        do_rd(a_cmp(2), d); check(d == 64'h30, "R7 comparator wrapped", d, 64'h30);
        do_wr(a_cfg(2), 64'h0);
    endtask

    task automatic t_collision;
        logic [63:0] d;
        quiesce(64'd0);
        do_wr(a_cfg(0), 64'h6);
        do_wr(a_cmp(0), 64'd20);
        do_wr(A_GCFG, 64'h1);
        repeat (20) @(posedge clk);
        do_wr(A_STS, 64'h1);   // lands on the edge that registers the match
        check(irq[0] == 1'b1, "R8 irq after collision", 64'(irq), 1);
        do_rd(A_STS, d); check(d == 1, "R8 set wins", d, 1);
        do_wr(a_cfg(0), 64'h2);
        check(irq[0] == 1'b0, "R5 enable gates irq", 64'(irq), 0);
        do_rd(A_STS, d); check(d == 1, "R5 status kept", d, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_cap();
        t_counter();
        t_level_oneshot();
        t_edge_periodic();
        t_mode32();
        t_collision();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule